// File: doc/BRIEF.md
# Endian-Configurable Byte-Lane Memory Slave

This block is a small synchronous memory that sits on a 32-bit processor data bus and serves byte, halfword and word transfers. Each cycle it receives a byte address, a two-bit transfer-size code, a write strobe, a 32-bit write bus and a select for big- or little-endian lane ordering. On a write it works out which of the four byte lanes the transfer covers and updates only those bytes of the addressed word. Each new byte comes from the lane of the write bus that the byte occupies. A master that copies a sub-word value onto every lane is therefore served correctly.

Every read is registered. One cycle after an address is presented, the complete stored word appears on the read bus. The requested byte or halfword sits on the lanes that the endian mapping assigns to it. The other lanes carry the neighbouring bytes of the same word. Shifting the value down into the low bits is left to the requester. Storage is a register array whose depth is a parameter. The word index wraps modulo that depth.

Top module: `lanemem_top`

## Requirements
- R1: Size code 2'b10 (word) writes all four byte lanes, whatever the values of addr[1:0] and big_end.
- R2: Size code 2'b01 (halfword) with big_end=0 writes lanes wdata[15:0] when addr[1]=0 and lanes wdata[31:16] when addr[1]=1.
- R3: A halfword with big_end=1 writes wdata[31:16] when addr[1]=0 and wdata[15:0] when addr[1]=1.
- R4: Size code 2'b00 (byte) with big_end=0 writes byte lane addr[1:0], where lane k is bits [8k+7:8k].
- R5: A byte with big_end=1 writes byte lane 3-addr[1:0].
- R6: Each written byte takes its value from the same lane of wdata. All bytes of the word outside the selected lanes keep their stored value.
- R7: Size code 2'b11 is reserved and changes no stored byte, even with wr=1.
- R8: rdata equals the whole stored word at the index presented one clock earlier. On a write to that index in the same cycle, rdata shows the contents before the write.
- R9: The word index is addr[ADDR_W-1:2] modulo DEPTH, so addresses that differ only above the index bits reach the same word.
- R10: A synchronous active-high rst sets rdata to 0 on the next clock edge. Stored words are kept through reset.
- R11: With wr=0 no stored byte changes, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the read register |
| addr | input | ADDR_W | Byte address of the transfer |
| size | input | 2 | Transfer size: 00 byte, 01 halfword, 10 word, 11 reserved |
| wr | input | 1 | Write strobe; high commits a write at the clock edge |
| big_end | input | 1 | Lane order: 0 little-endian, 1 big-endian |
| wdata | input | 32 | Write bus, one byte per lane |
| rdata | output | 32 | Registered whole-word read data |

## Verification
The hardest case to bring about is a sub-word write that picks the wrong lane but still leaves the right bytes in memory. This is exactly what happens when the master copies its value across all lanes. The stimulus therefore puts a different value on each write lane and writes onto a word preloaded with a known pattern. Any wrong lane choice or stray byte enable then shows up in the word read back. The sweep covers every combination of size code, low address bits and endian select at two word indices. A write and a read to the same word in one cycle are forced directly to expose the read-before-write order.

// File: rtl/lanemem_pkg.sv
package lanemem_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int DATA_W = LANES * BYTE_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } xfer_size_e;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;
endpackage

// File: rtl/lanemem_lane_decode.sv
// Maps size code, low address bits and lane order onto the set of byte lanes
// that a transfer covers. The reserved size code selects no lane.
module lanemem_lane_decode
    import lanemem_pkg::*;
(
    input  logic [1:0]       size,
    input  logic [1:0]       addr_lo,
    input  logic             big_end,
    output logic [LANES-1:0] lane_sel
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // position of this lane counted in address order for each lane order
        localparam logic [1:0] BYTE_POS_LE = 2'(i);
        localparam logic [1:0] BYTE_POS_BE = 2'(LANES - 1 - i);
        localparam logic       HALF_POS_LE = 1'(i / 2);
        localparam logic       HALF_POS_BE = 1'(1 - (i / 2));

        logic hit;
        always_comb begin
            hit = 1'b0;
            unique case (xfer_size_e'(size))
                SZ_WORD: hit = 1'b1;
                SZ_HALF: hit = (addr_lo[1] == (big_end ? HALF_POS_BE : HALF_POS_LE));
                SZ_BYTE: hit = (addr_lo == (big_end ? BYTE_POS_BE : BYTE_POS_LE));
                default: hit = 1'b0;
            endcase
        end
        assign lane_sel[i] = hit;
    end
endmodule

// File: rtl/lanemem_store.sv
// Word array with one write enable per byte lane and an unregistered read port.
module lanemem_store
    import lanemem_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                         clk,
    input  logic [IDX_W-1:0]             idx,
    input  logic [LANES-1:0]             lane_we,
    input  logic [LANES-1:0][BYTE_W-1:0] wbytes,
    output logic [DATA_W-1:0]            rd_word
);
    logic [LANES-1:0][BYTE_W-1:0] mem_q [DEPTH];
    logic [LANES-1:0][BYTE_W-1:0] mem_d [DEPTH];

    always_comb begin
        for (int w = 0; w < DEPTH; w++) begin
            mem_d[w] = mem_q[w];
        end
        for (int b = 0; b < LANES; b++) begin
            if (lane_we[b]) begin
                mem_d[idx][b] = wbytes[b];
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int w = 0; w < DEPTH; w++) begin
            mem_q[w] <= mem_d[w];
        end
    end

    assign rd_word = mem_q[idx];
endmodule

// File: rtl/lanemem_top.sv
module lanemem_top
    import lanemem_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              wr,
    input  logic              big_end,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int WADR_W = ADDR_W - 2;

    logic [WADR_W-1:0]            word_addr;
    logic [IDX_W-1:0]             idx;
    logic [LANES-1:0]             lane_sel;
    logic [LANES-1:0]             lane_we;
    logic [LANES-1:0][BYTE_W-1:0] wbytes;
    logic [DATA_W-1:0]            rd_word;
    rd_state_t                    st_d, st_q;

    assign word_addr = addr[ADDR_W-1:2];
    assign idx       = IDX_W'(word_addr % WADR_W'(DEPTH));
    assign wbytes    = wdata;

    lanemem_lane_decode u_decode (
        .size     (size),
        .addr_lo  (addr[1:0]),
        .big_end  (big_end),
        .lane_sel (lane_sel)
    );

    assign lane_we = lane_sel & {LANES{wr}};

    lanemem_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .idx     (idx),
        .lane_we (lane_we),
        .wbytes  (wbytes),
        .rd_word (rd_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rdata = rd_word;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
endmodule

// File: rtl/lanemem_chk.sv
module lanemem_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  size,
    input logic [1:0]  addr_lo,
    input logic        big_end,
    input logic        wr,
    input logic [3:0]  lane_sel,
    input logic [3:0]  lane_we,
    input logic [31:0] rd_word,
    input logic [31:0] rdata
);
    AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
        (size == 2'b10) |-> (lane_sel == 4'b1111)); // R1
    AST_HALF_LE_LANES: assert property (@(posedge clk) disable iff (rst)
        (size == 2'b01 && !big_end) |-> (lane_sel == (addr_lo[1] ? 4'b1100 : 4'b0011))); // R2
    AST_HALF_BE_LANES: assert property (@(posedge clk) disable iff (rst)
        (size == 2'b01 && big_end) |-> (lane_sel == (addr_lo[1] ? 4'b0011 : 4'b1100))); // R3
    AST_BYTE_LE_LANE: assert property (@(posedge clk) disable iff (rst)
        (size == 2'b00 && !big_end) |-> (lane_sel == (4'b0001 << addr_lo))); // R4
    AST_BYTE_BE_LANE: assert property (@(posedge clk) disable iff (rst)
        (size == 2'b00 && big_end) |-> (lane_sel == (4'b1000 >> addr_lo))); // R5
    AST_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (size == 2'b11) |-> (lane_we == 4'b0000)); // R7
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!wr) |-> (lane_we == 4'b0000)); // R11
    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rdata == $past(rd_word))); // R8
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rdata == 32'h0)); // R10
endmodule

bind lanemem_top lanemem_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .size     (size),
    .addr_lo  (addr[1:0]),
    .big_end  (big_end),
    .wr       (wr),
    .lane_sel (lane_sel),
    .lane_we  (lane_we),
    .rd_word  (rd_word),
    .rdata    (rdata)
);

// File: tb/tb_lanemem_top.sv
module tb_lanemem_top;
    localparam int ADDR_W = 12;
    localparam int DEPTH  = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        size;
    logic              wr;
    logic              big_end;
    logic [31:0]       wdata;
    logic [31:0]       rdata;

    always #5 clk = ~clk;

    lanemem_top #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .addr(addr), .size(size), .wr(wr),
        .big_end(big_end), .wdata(wdata), .rdata(rdata)
    );

    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;
    logic [31:0] model [DEPTH];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected lane set, from the lane mapping in the requirements
    function automatic logic [3:0] exp_mask(input int sz, input int lo, input int be);
        int k;
        case (sz)
            2: return 4'hF;
            1: begin
                k = (lo / 2);
                if (be != 0) k = 1 - k;
                return 4'(3 << (2 * k));
            end
            0: begin
                k = (be != 0) ? 3 - lo : lo;
                return 4'(1 << k);
            end
            default: return 4'h0;
        endcase
    endfunction

    function automatic string req_tag(input int sz, input int be);
        case (sz)
            2: return "R1,R6";
            1: return (be != 0) ? "R3,R6" : "R2,R6";
            0: return (be != 0) ? "R5,R6" : "R4,R6";
            default: return "R7";
        endcase
    endfunction

    // entered and left at a falling edge
    task automatic do_write(input int a, input int sz, input int be, input logic [31:0] d);
        addr = ADDR_W'(a); size = 2'(sz); big_end = be[0]; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic do_read(input int a, output logic [31:0] d);
        addr = ADDR_W'(a); wr = 1'b0;
        @(negedge clk);
        d = rdata;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        logic [31:0] d;
        logic [3:0]  m;
        rst = 1'b1; addr = '0; size = 2'b10; wr = 1'b0; big_end = 1'b0; wdata = '0;
        repeat (3) @(negedge clk);
        check("R10", rdata, 32'h0);
        rst = 1'b0;

        // sweep: every size, low address and lane order on two words
        for (int be = 0; be < 2; be++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int lo = 0; lo < 4; lo++) begin
                    for (int wsel = 0; wsel < 2; wsel++) begin
                        int wi;
                        int a;
                        wi = (wsel == 0) ? 2 : 13;
                        a  = wi * 4 + lo;
                        model[wi] = {8'(wi * 16 + lo), 8'(sz * 4 + be), 8'h5A ^ 8'(lo), 8'hC3};
                        do_write(wi * 4, 2, 0, model[wi]);
                        d = {8'hD0 ^ 8'(sz), 8'hA0 ^ 8'(lo), 8'h60 ^ 8'(be), 8'h10 ^ 8'(wi)};
                        do_write(a, sz, be, d);
                        m = exp_mask(sz, lo, be);
                        for (int k = 0; k < 4; k++) begin
                            if (m[k]) model[wi][8*k +: 8] = d[8*k +: 8];
                        end
                        do_read(a, got);
                        check(req_tag(sz, be), got, model[wi]);
                    end
                end
            end
        end

        // read-before-write on the same word
        model[5] = 32'h0BAD_F00D;
        do_write(5 * 4, 2, 0, model[5]);
        addr = ADDR_W'(5 * 4); size = 2'b10; wdata = 32'h1234_5678; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        check("R8", rdata, 32'h0BAD_F00D);
        model[5] = 32'h1234_5678;
        do_read(5 * 4 + 2, got);
        check("R8", got, model[5]);

        // index aliasing above the index bits
        do_write((7 + DEPTH * 3) * 4, 2, 0, 32'hCAFE_0007);
        model[7] = 32'hCAFE_0007;
        do_read(7 * 4, got);
        check("R9", got, model[7]);
        do_read((7 + DEPTH * 9) * 4 + 1, got);
        check("R9", got, model[7]);

        // idle strobe changes nothing
        model[9] = 32'h9999_AAAA;
        do_write(9 * 4, 2, 0, model[9]);
        addr = ADDR_W'(9 * 4); size = 2'b10; wdata = 32'hFFFF_0000; wr = 1'b0;
        @(negedge clk);
        do_read(9 * 4, got);
        check("R11", got, model[9]);

        // reserved code with the strobe high, both lane orders
        do_write(9 * 4 + 1, 3, 1, 32'h0);
        do_write(9 * 4 + 3, 3, 0, 32'h0);
        do_read(9 * 4, got);
        check("R7", got, model[9]);

        // reset clears the read register but keeps storage
        do_read(9 * 4, got);
        check("R10", got, model[9]);
        rst = 1'b1;
        @(negedge clk);
        check("R10", rdata, 32'h0);
        rst = 1'b0;
        do_read(9 * 4, got);
        check("R10", got, model[9]);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule